// File: doc/BRIEF.md
# Serial Multiply-Accumulate FIR Filter

This block computes a finite impulse response filter of `TAPS` taps with one shared multiplier and one accumulator. Each accepted input sample starts a sweep of `TAPS` clock cycles. During the sweep, one counter walks through every tap, and the block forms one product per cycle. A capture register holds the finished sum and presents it for one cycle. The internal clock therefore runs about `TAPS` times faster than the sample stream.

The coefficients are fixed when the block is elaborated. They are passed as a packed parameter, with tap `i` at bits `[i*CW +: CW]`. The ROM stores them back to front. The delay line holds its oldest sample at address 0. With this layout, the same counter value picks the matching sample and coefficient. The accumulator does not clear between sums. It reloads with the first product of the new sum. Its width, `AW`, comes from the sum of the absolute coefficient values.

The controller has two named states. `ST_IDLE` waits for a sample with `in_ready` high. `ST_SWEEP` runs the counter from 0 to `TAPS-1`. The transition `ST_IDLE -> ST_SWEEP` happens when a sample is accepted. The transition `ST_SWEEP -> ST_IDLE` happens when the counter reaches `TAPS-1`. No other transitions exist.

Top module: `serial_fir`

## Requirements
- R1: After reset, each output equals the sum over i = 0..TAPS-1 of h[i]·x[n−i]. Here x[n] is the sample just accepted, and samples older than the first one after reset count as zero.
- R2: After an accepted sample, `busy` is high and `in_ready` is low for exactly `TAPS` cycles. After that, `in_ready` returns high.
- R3: An `in_valid` pulse while `in_ready` is low is ignored. No sample enters the delay line, no extra output appears, and later outputs are unchanged.
- R4: If a sample is accepted at rising edge k, `out_valid` is high for exactly one cycle, the one following edge k+TAPS+2. It is low at every other time.
- R5: Each sum starts fresh. An impulse followed by zeros produces h[0], h[1], …, h[TAPS−1] in that order, and then zeros, with no carry-over from the previous sum.
- R6: The output width is `AW = DW + ceil(log2(S+1))`, where S = sum of |h[i]|. Full-scale positive and negative inputs, including the most negative value, produce the exact signed result in two's complement.
- R7: A synchronous reset clears the delay line, the counter and the capture register. Afterwards `in_ready`=1, `busy`=0, `out_valid`=0 and `out_data`=0. This holds even when reset arrives in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_data | input | DW | Signed input sample |
| in_ready | output | 1 | Block is idle and will take a sample |
| busy | output | 1 | A tap sweep is running |
| out_valid | output | 1 | One-cycle pulse marking a new output |
| out_data | output | AW | Signed filter output, held until the next capture |

## Verification
The hardest situation to reach is a sample offered in the middle of a sweep, because a well-behaved source never does this. The stimulus deliberately raises `in_valid` with a nonzero value two cycles into some sweeps. It then checks that no output appears early and that every later output still matches the reference convolution. A second hard case is a reset in the middle of a stream while the delay line holds nonzero history. This case is reached by asserting reset after nonzero samples and then sending an impulse, whose response exposes any leftover state.

// File: rtl/fir_pkg.sv
package fir_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } fir_state_t;

    // Output width from the absolute coefficient sum.
    function automatic int acc_width(input int dw, input int taps, input int cw,
                                     input logic [4095:0] cvec);
        int total;
        total = 0;
        for (int i = 0; i < taps; i++) begin
            logic signed [31:0] v;
            for (int b = 0; b < 32; b++) begin
                if (b < cw) v[b] = cvec[i*cw + b];
                else        v[b] = cvec[i*cw + cw - 1];
            end
            total += (v < 0) ? -v : v;
        end
        return dw + $clog2(total + 1);
    endfunction

endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
    parameter int TAPS = 8,
    parameter int DW   = 8,
    parameter int CNTW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    input  logic [CNTW-1:0]      rd_addr,
    output logic signed [DW-1:0] dout
);
    // Oldest sample at index 0, newest at TAPS-1.
    logic signed [DW-1:0] mem [TAPS];

    always_ff @(posedge clk) begin
        if (rst) mem[TAPS-1] <= '0;
        else if (shift_en) mem[TAPS-1] <= din;
    end

    generate
        for (genvar i = 0; i < TAPS - 1; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) mem[i] <= '0;
                else if (shift_en) mem[i] <= mem[i+1];
            end
        end
    endgenerate

    assign dout = mem[rd_addr];

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(mem[TAPS-1]));

endmodule

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
    parameter int                     TAPS  = 8,
    parameter int                     CW    = 6,
    parameter logic [TAPS*CW-1:0]     COEFS = '0,
    parameter int                     CNTW  = 3
) (
    input  logic [CNTW-1:0]      addr,
    output logic signed [CW-1:0] coef
);
    logic signed [CW-1:0] rom [TAPS];

    // Reversed storage: entry a holds tap TAPS-1-a.
    generate
        for (genvar a = 0; a < TAPS; a++) begin : g_entry
            assign rom[a] = COEFS[(TAPS-1-a)*CW +: CW];
        end
    endgenerate

    assign coef = rom[addr];

endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int DW = 8,
    parameter int CW = 6,
    parameter int AW = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_v,
    input  logic                 step_first,
    input  logic                 step_last,
    input  logic signed [DW-1:0] sample,
    input  logic signed [CW-1:0] coef,
    output logic                 sum_done,
    output logic signed [AW-1:0] sum
);
    localparam int PW = (DW + CW > AW) ? DW + CW : AW;

    logic signed [PW-1:0] mult;
    logic signed [PW-1:0] prod_q;
    logic                 prod_v, prod_first, prod_last;
    logic signed [AW-1:0] acc;

    assign mult = PW'(sample) * PW'(coef);

    // Product register stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q     <= '0;
            prod_v     <= 1'b0;
            prod_first <= 1'b0;
            prod_last  <= 1'b0;
        end else begin
            prod_q     <= mult;
            prod_v     <= step_v;
            prod_first <= step_first;
            prod_last  <= step_last;
        end
    end

    // Accumulator: reload on the first product, otherwise add.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            sum_done <= 1'b0;
        end else begin
            sum_done <= prod_v && prod_last;
            if (prod_v) begin
                if (prod_first) acc <= prod_q[AW-1:0];
                else            acc <= acc + prod_q[AW-1:0];
            end
        end
    end

    assign sum = acc;

    // R5
    reload_first_chk: assert property (@(posedge clk) disable iff (rst)
        (prod_v && prod_first) |=> (acc == $past(prod_q[AW-1:0])));

endmodule

// File: rtl/serial_fir.sv
module serial_fir #(
    parameter int                 TAPS  = 8,
    parameter int                 CW    = 6,
    parameter logic [TAPS*CW-1:0] COEFS = {6'h01, 6'h3E, 6'h04, 6'h37,
                                           6'h0C, 6'h07, 6'h3B, 6'h03},
    parameter int                 DW    = 8,
    parameter int                 AW    = fir_pkg::acc_width(DW, TAPS, CW, 4096'(COEFS))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          busy,
    output logic          out_valid,
    output logic [AW-1:0] out_data
);
    import fir_pkg::*;

    localparam int CNTW = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam logic [CNTW-1:0] LAST_TAP = CNTW'(TAPS - 1);

    fir_state_t           state, state_nx;
    logic [CNTW-1:0]      cnt, cnt_nx;
    logic                 accept;
    logic                 step_first, step_last;
    logic signed [DW-1:0] tap_sample;
    logic signed [CW-1:0] tap_coef;
    logic                 sum_done;
    logic signed [AW-1:0] sum;

    assign accept = in_valid && in_ready;

    // Next-state logic.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (accept) state_nx = ST_SWEEP;
            end
            ST_SWEEP: begin
                if (cnt == LAST_TAP) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // State-decoded outputs.
    always_comb begin
        in_ready   = (state == ST_IDLE);
        busy       = (state == ST_SWEEP);
        step_first = (state == ST_SWEEP) && (cnt == '0);
        step_last  = (state == ST_SWEEP) && (cnt == LAST_TAP);
    end

    fir_delay_line #(.TAPS(TAPS), .DW(DW), .CNTW(CNTW)) u_line (
        .clk(clk), .rst(rst), .shift_en(accept), .din(in_data),
        .rd_addr(cnt), .dout(tap_sample)
    );

    fir_coef_rom #(.TAPS(TAPS), .CW(CW), .COEFS(COEFS), .CNTW(CNTW)) u_rom (
        .addr(cnt), .coef(tap_coef)
    );

    fir_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
        .clk(clk), .rst(rst), .step_v(busy), .step_first(step_first),
        .step_last(step_last), .sample(tap_sample), .coef(tap_coef),
        .sum_done(sum_done), .sum(sum)
    );

    // Capture register, one pulse per sweep.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= sum_done;
            if (sum_done) out_data <= sum;
        end
    end

    // R2
    sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && !in_ready && cnt == '0));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_TAP);

    // R4
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    out_timing_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(busy, 3) && !$past(busy, 2)));

endmodule

// File: tb/serial_fir_bench.sv
module serial_fir_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int DW = 8;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, busy, out_valid;
    logic [AW-1:0] out_data;

    int total = 0;
    int bad   = 0;
    int h    [N] = '{3, -5, 7, 12, -9, 4, -2, 1};
    int hist [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_fir u_serial_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .busy(busy), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < N; i++) hist[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_hist();
        // R7: state after reset
        check(in_ready && !busy && !out_valid && out_data == '0, "R7",
              {out_valid, busy, in_ready}, 3'b001);
        check($signed(out_data) == 0, "R7", $signed(out_data), 0);
    endtask

    // Sends one sample; poke=1 offers an extra sample mid-sweep (R3).
    task automatic send(input int x, input bit poke, input string req);
        int  expv;
        bit  ctl_ok;
        bit  early;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        expv = 0;
        for (int i = 0; i < N; i++) expv += h[i] * hist[i];
        ctl_ok = 1'b1;
        early  = 1'b0;
        for (int j = 0; j <= N + 2; j++) begin
            @(negedge clk);
            if (j == 0) in_valid = 1'b0;
            if (poke && j == 2) begin in_valid = 1'b1; in_data = DW'(55); end
            if (poke && j == 3) in_valid = 1'b0;
            if (j < N && !(busy && !in_ready)) ctl_ok = 1'b0;
            if (j == N && !(in_ready && !busy)) ctl_ok = 1'b0;
            if (j < N + 2 && out_valid) early = 1'b1;
            if (j == N + 2) begin
                // R4: one pulse at edge k+N+2
                check(out_valid && !early, "R4", {early, out_valid}, 2'b01);
                // R1 convolution result (also R5/R6 via req)
                check($signed(out_data) == expv, req, $signed(out_data), expv);
            end
        end
        // R2: busy window and ready return
        check(ctl_ok, "R2", ctl_ok, 1);
        if (poke) begin
            @(negedge clk);
            // R3: poked sample produced no output
            check(!out_valid, "R3", out_valid, 0);
        end
    endtask

    initial begin
        logic [7:0] lfsr;
        clear_hist();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(in_ready && !busy && !out_valid, "R7", {out_valid, busy, in_ready}, 3'b001);
        // R5: impulse gives coefficients in order, then zeros
        send(1, 1'b0, "R5");
        for (int i = 0; i < N + 2; i++) send(0, 1'b0, "R5");
        // R1: step
        for (int i = 0; i < N + 2; i++) send(5, 1'b0, "R1");
        // R6: full-scale positive and negative
        for (int i = 0; i < N + 1; i++) send(127, 1'b0, "R6");
        for (int i = 0; i < N + 1; i++) send(-128, 1'b0, "R6");
        // R6: sign pattern aligned with coefficients
        for (int i = 0; i < 2 * N; i++) send(((i % 3) == 0) ? -128 : 127, 1'b0, "R6");
        // R3: samples offered during a sweep are ignored
        for (int i = 0; i < N + 2; i++) send(i * 7 - 20, 1'b1, "R3");
        // R1: pseudo-random sweep
        lfsr = 8'hA5;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            send($signed(lfsr), 1'b0, "R1");
        end
        // R7: reset mid-stream clears history
        send(100, 1'b0, "R1");
        send(-77, 1'b0, "R1");
        do_reset();
        send(1, 1'b0, "R7");
        for (int i = 0; i < N; i++) send(0, 1'b0, "R7");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule